// File: doc/BRIEF.md
# Motion Burst Readout Sequencer

This block sits beside the serial slave port of a motion-sensing device. It turns one read of a reserved burst address into a multi-byte readout. The serial port reports each completed address phase on a one-cycle strobe, together with the address and its direction. When that address is the burst address and the access is a read, the sequencer copies every motion and image-quality value into a private snapshot in that same cycle. It then offers the copied bytes one after another on an outgoing byte stream. The shift logic that drives the serial data line pulls bytes from this stream.

The fixed byte list is: horizontal motion, vertical motion, surface quality, shutter high byte, shutter low byte, peak pixel, pixel sum. Each accepted byte moves a saturating position counter forward by one. Once the pixel-sum byte is reached, that byte is offered again for every further pull. While a burst runs, every address strobe is ignored, including a second burst request. Only a release of chip select ends the burst. The two motion bytes keep their clear-on-read behaviour: a strobe tells the motion accumulator when each of them is loaded for output.

The outgoing stream is valid/ready. The sequencer holds `tx_valid` high and `tx_data` stable for as long as `tx_ready` stays low, so the shifter may apply back-pressure for any length of time. A byte counts as transferred on a cycle where both `tx_valid` and `tx_ready` are high. Chip-select and address inputs are plain control pins with no handshake.

Top module: `burst_readout_seq`

## Requirements
- R1: A burst starts in a cycle where `cs_n` is 0 and `addr_valid` is 1, with `addr_rd` 1 (read) and `addr` equal to 0x63, while no burst is running. In the following cycle `burst_active` and `tx_valid` are 1 and `tx_data` equals the `dx_in` value sampled in the start cycle.
- R2: Each transfer (`tx_valid` and `tx_ready` both 1) advances the offered byte one entry through the fixed list. The list is: index 0 horizontal motion, 1 vertical motion, 2 surface quality, 3 `shutter_in[15:8]`, 4 `shutter_in[7:0]`, 5 peak pixel, 6 pixel sum.
- R3: All seven bytes are captured in the start cycle. Later changes on any live input do not alter the bytes that the burst returns.
- R4: After the pixel-sum byte has been offered, every further transfer returns the pixel-sum byte again.
- R5: The stream has no gaps. While a burst runs with `cs_n` 0, `tx_valid` stays 1, and the next byte is offered in the cycle right after a transfer.
- R6: During a burst, `addr_valid` strobes of any address or direction are ignored. This includes a second burst request: the offered byte and the list position are unchanged.
- R7: `cs_n` at 1 ends the burst at the next clock edge, whatever the list position. `burst_active` and `tx_valid` go to 0 and `tx_data` goes to 0x00. A transfer in that same cycle is discarded. Holding `cs_n` low again does not restart the burst without a new burst request.
- R8: An address strobe starts nothing in three cases: a write (`addr_rd` 0), any address other than 0x63, or `cs_n` at 1.
- R9: `clr_dx` pulses for exactly one cycle, together with the first offered byte. `clr_dy` pulses for exactly one cycle, in the cycle right after the first byte is transferred. Each fires at most once per burst, and the two never fire together.
- R10: After reset, `burst_active`, `tx_valid`, `clr_dx` and `clr_dy` are 0 and `tx_data` is 0x00.
- R11: While `tx_ready` is 0, `tx_data` and the list position hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Synchronised chip select, active low |
| addr_valid | input | 1 | One-cycle strobe: an address phase has just completed |
| addr_rd | input | 1 | Direction of that address phase, 1 = read |
| addr | input | 7 | Register address of that phase |
| dx_in | input | 8 | Live horizontal motion count |
| dy_in | input | 8 | Live vertical motion count |
| squal_in | input | 8 | Live surface quality |
| shutter_in | input | 16 | Live shutter value |
| peak_in | input | 8 | Live peak pixel value |
| psum_in | input | 8 | Live pixel sum byte |
| burst_active | output | 1 | A burst is in progress |
| tx_valid | output | 1 | Outgoing byte is valid |
| tx_ready | input | 1 | Shifter accepts the outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| clr_dx | output | 1 | Clear strobe for the horizontal motion accumulator |
| clr_dy | output | 1 | Clear strobe for the vertical motion accumulator |

## Verification
The bench drives live values that change while the burst is running. A design that forwards live values instead of the snapshot would return the new values, not the ones frozen at the start. It pulls past the end of the list, which catches a counter that wraps back to horizontal motion or runs into an undefined slot. Burst and non-burst address strobes arrive mid-burst; a design that re-decodes them would restart at the first byte or pulse `clr_dx` again. Chip select is released mid-list and in the same cycle as a transfer, then held low again with no new request, which exposes a stale position or an automatic restart.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 7;
  localparam int NUM_ENTRIES = 7;
  localparam int IDX_W       = $clog2(NUM_ENTRIES);
  localparam int LAST_IDX    = NUM_ENTRIES - 1;
  localparam logic [ADDR_W-1:0] BURST_ADDR = 7'h63;

  // list position; order is behaviour and must not change
  typedef enum logic [IDX_W-1:0] {
    SLOT_DX  = 3'd0,
    SLOT_DY  = 3'd1,
    SLOT_SQ  = 3'd2,
    SLOT_SHH = 3'd3,
    SLOT_SHL = 3'd4,
    SLOT_PK  = 3'd5,
    SLOT_SUM = 3'd6
  } slot_e;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] BADDR = BURST_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          addr_valid,
  input  logic          addr_rd,
  input  logic [AW-1:0] addr,
  input  logic          tx_ready,
  output logic          active,
  output logic          start,
  output logic          adv,
  output logic          stop
);
  logic active_q;

  // decode only while idle; a running burst ignores every address
  assign start  = !active_q && !cs_n && addr_valid && addr_rd && (addr == BADDR);
  assign stop   = cs_n;
  assign adv    = active_q && !cs_n && tx_ready;
  assign active = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     active_q <= 1'b0;
    else if (stop)  active_q <= 1'b0;
    else if (start) active_q <= 1'b1;
  end
endmodule

// File: rtl/burst_index.sv
module burst_index
  import burst_seq_pkg::*;
#(
  parameter int N  = NUM_ENTRIES,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adv,
  input  logic          stop,
  output logic [IW-1:0] idx,
  output logic          load_first,
  output logic          load_second
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] idx_q;
  logic          first_q, second_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      first_q  <= 1'b0;
      second_q <= 1'b0;
    end else begin
      first_q  <= start && !stop;
      second_q <= adv && (idx_q == '0);
      if (stop || start)              idx_q <= '0;
      else if (adv && idx_q != LAST)  idx_q <= idx_q + 1'b1;
    end
  end

  assign idx         = idx_q;
  assign load_first  = first_q;
  assign load_second = second_q;
endmodule

// File: rtl/burst_snapshot.sv
module burst_snapshot
  import burst_seq_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int N  = NUM_ENTRIES,
  parameter int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [N*BW-1:0] live,
  input  logic [IW-1:0]   sel,
  output logic [BW-1:0]   dout
);
  logic [BW-1:0] snap_q [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       snap_q[g] <= '0;
      else if (capture) snap_q[g] <= live[g*BW +: BW];
    end
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++)
      if (sel == IW'(i)) dout = snap_q[i];
  end
endmodule

// File: rtl/burst_readout_seq.sv
module burst_readout_seq
  import burst_seq_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] BADDR = BURST_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          addr_valid,
  input  logic          addr_rd,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] dx_in,
  input  logic [BW-1:0] dy_in,
  input  logic [BW-1:0] squal_in,
  input  logic [2*BW-1:0] shutter_in,
  input  logic [BW-1:0] peak_in,
  input  logic [BW-1:0] psum_in,
  output logic          burst_active,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [BW-1:0] tx_data,
  output logic          clr_dx,
  output logic          clr_dy
);
  localparam int N  = NUM_ENTRIES;
  localparam int IW = $clog2(N);

  logic          active, start, adv, stop;
  logic [IW-1:0] idx;
  logic [BW-1:0] sel_byte;
  logic [N*BW-1:0] live;

  // entry g sits at live[g*BW +: BW], following slot_e
  assign live = {psum_in, peak_in, shutter_in[BW-1:0], shutter_in[2*BW-1:BW],
                 squal_in, dy_in, dx_in};

  burst_ctrl #(.AW(AW), .BADDR(BADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr_valid(addr_valid),
    .addr_rd(addr_rd), .addr(addr), .tx_ready(tx_ready),
    .active(active), .start(start), .adv(adv), .stop(stop)
  );

  burst_index #(.N(N), .IW(IW)) u_idx (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(adv), .stop(stop),
    .idx(idx), .load_first(clr_dx), .load_second(clr_dy)
  );

  burst_snapshot #(.BW(BW), .N(N), .IW(IW)) u_snap (
    .clk(clk), .rst_n(rst_n), .capture(start), .live(live),
    .sel(idx), .dout(sel_byte)
  );

  assign burst_active = active;
  assign tx_valid     = active;
  assign tx_data      = active ? sel_byte : '0;
endmodule

// File: rtl/burst_readout_seq_chk.sv
module burst_readout_seq_chk #(
  parameter int BW = 8,
  parameter int AW = 7,
  parameter logic [AW-1:0] BADDR = 7'h63
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          addr_valid,
  input logic          addr_rd,
  input logic [AW-1:0] addr,
  input logic [BW-1:0] dx_in,
  input logic          burst_active,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [BW-1:0] tx_data,
  input logic          clr_dx,
  input logic          clr_dy
);
  logic req;
  assign req = !cs_n && addr_valid && addr_rd && (addr == BADDR);

  a_r1_start_offers_dx: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_active && req) |=> (burst_active && tx_valid && tx_data == $past(dx_in)));

  a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !cs_n) |=> tx_valid);

  a_r6_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !cs_n) |=> (burst_active && !clr_dx));

  a_r7_cs_ends: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!burst_active && !tx_valid && tx_data == '0));

  a_r8_no_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_active && !req) |=> !burst_active);

  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_dx, clr_dy}));

  a_r9_dx_single: assert property (@(posedge clk) disable iff (!rst_n)
    clr_dx |=> !clr_dx);

  a_r9_dy_single: assert property (@(posedge clk) disable iff (!rst_n)
    clr_dy |=> !clr_dy);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !cs_n) |=> $stable(tx_data));
endmodule

bind burst_readout_seq burst_readout_seq_chk #(.BW(BW), .AW(AW), .BADDR(BADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr_valid(addr_valid),
  .addr_rd(addr_rd), .addr(addr), .dx_in(dx_in), .burst_active(burst_active),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .clr_dx(clr_dx), .clr_dy(clr_dy)
);

// File: tb/burst_readout_seq_tb.sv
module burst_readout_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        addr_valid = 1'b0;
  logic        addr_rd = 1'b0;
  logic [6:0]  addr = '0;
  logic [7:0]  dx_in = '0, dy_in = '0, squal_in = '0, peak_in = '0, psum_in = '0;
  logic [15:0] shutter_in = '0;
  logic        tx_ready = 1'b0;
  logic        burst_active, tx_valid, clr_dx, clr_dy;
  logic [7:0]  tx_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_list [7];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_readout_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr_valid(addr_valid),
    .addr_rd(addr_rd), .addr(addr), .dx_in(dx_in), .dy_in(dy_in),
    .squal_in(squal_in), .shutter_in(shutter_in), .peak_in(peak_in),
    .psum_in(psum_in), .burst_active(burst_active), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .clr_dx(clr_dx), .clr_dy(clr_dy)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_live(input logic [7:0] base);
    dx_in = base; dy_in = base + 8'h1; squal_in = base + 8'h2;
    shutter_in = {base + 8'h3, base + 8'h4}; peak_in = base + 8'h5; psum_in = base + 8'h6;
    exp_list[0] = dx_in; exp_list[1] = dy_in; exp_list[2] = squal_in;
    exp_list[3] = shutter_in[15:8]; exp_list[4] = shutter_in[7:0];
    exp_list[5] = peak_in; exp_list[6] = psum_in;
  endtask

  task automatic addr_strobe(input logic rd, input logic [6:0] a);
    addr_rd = rd; addr = a; addr_valid = 1'b1;
    step();
    addr_valid = 1'b0;
  endtask

  task automatic xfer();
    tx_ready = 1'b1;
    step();
    tx_ready = 1'b0;
  endtask

  task automatic finish_burst();
    cs_n = 1'b1; step(); step();
  endtask

  task automatic t_reset();
    chk("R10 active", burst_active, 0);
    chk("R10 valid", tx_valid, 0);
    chk("R10 data", tx_data, 8'h00);
    chk("R10 strobes", {clr_dx, clr_dy}, 0);
  endtask

  task automatic t_order_and_saturate();
    set_live(8'h40);
    cs_n = 1'b0; step();
    addr_strobe(1'b1, 7'h63);
    chk("R1 active", burst_active, 1);
    chk("R1 first byte", tx_data, exp_list[0]);
    chk("R9 clr_dx with first", {clr_dx, clr_dy}, 2'b10);
    for (int i = 1; i < 7; i++) begin
      xfer();
      chk("R2 order", tx_data, exp_list[i]);
      chk("R5 valid after transfer", tx_valid, 1);
      chk("R9 clr_dy timing", {clr_dx, clr_dy}, (i == 1) ? 2'b01 : 2'b00);
    end
    for (int i = 0; i < 3; i++) begin
      xfer();
      chk("R4 repeat pixel sum", tx_data, exp_list[6]);
      chk("R9 no further strobe", {clr_dx, clr_dy}, 2'b00);
    end
    cs_n = 1'b1; step();
    chk("R7 ends after list", {burst_active, tx_valid}, 2'b00);
    chk("R7 data cleared", tx_data, 8'h00);
    step();
  endtask

  task automatic t_snapshot_and_backpressure();
    set_live(8'h80);
    cs_n = 1'b0; step();
    addr_strobe(1'b1, 7'h63);
    dx_in = 8'hEE; dy_in = 8'hEE; squal_in = 8'hEE; shutter_in = 16'hEEEE;
    peak_in = 8'hEE; psum_in = 8'hEE;
    xfer();
    chk("R3 dy frozen", tx_data, exp_list[1]);
    for (int i = 0; i < 3; i++) begin
      dy_in = dy_in + 8'h1;
      step();
      chk("R11 held under back-pressure", tx_data, exp_list[1]);
      chk("R11 valid held", tx_valid, 1);
    end
    for (int i = 2; i < 7; i++) begin
      xfer();
      chk("R3 frozen byte", tx_data, exp_list[i]);
    end
    finish_burst();
  endtask

  task automatic t_addr_ignored();
    set_live(8'h20);
    cs_n = 1'b0; step();
    addr_strobe(1'b1, 7'h63);
    xfer();
    set_live(8'hA0);
    addr_strobe(1'b1, 7'h63);
    chk("R6 second burst request ignored", tx_data, 8'h21);
    chk("R6 no restart strobe", clr_dx, 0);
    addr_strobe(1'b0, 7'h0D);
    chk("R6 write ignored", tx_data, 8'h21);
    xfer();
    chk("R6 position kept", tx_data, 8'h22);
    finish_burst();
  endtask

  task automatic t_early_end();
    set_live(8'h10);
    cs_n = 1'b0; step();
    addr_strobe(1'b1, 7'h63);
    xfer();
    xfer();
    cs_n = 1'b1; tx_ready = 1'b1; step(); tx_ready = 1'b0;
    chk("R7 early end", {burst_active, tx_valid}, 2'b00);
    cs_n = 1'b0; step(); step();
    chk("R7 no auto restart", burst_active, 0);
    set_live(8'h60);
    addr_strobe(1'b1, 7'h63);
    chk("R7 new burst from first byte", tx_data, exp_list[0]);
    xfer();
    chk("R7 new burst second byte", tx_data, exp_list[1]);
    finish_burst();
  endtask

  task automatic t_no_start();
    set_live(8'h30);
    cs_n = 1'b0; step();
    addr_strobe(1'b0, 7'h63);
    chk("R8 write to burst addr", {burst_active, clr_dx}, 2'b00);
    addr_strobe(1'b1, 7'h62);
    chk("R8 other address", {burst_active, clr_dx}, 2'b00);
    cs_n = 1'b1;
    addr_strobe(1'b1, 7'h63);
    chk("R8 chip select high", {burst_active, tx_valid}, 2'b00);
    chk("R8 data idle", tx_data, 8'h00);
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_order_and_saturate();
    t_snapshot_and_backpressure();
    t_addr_ignored();
    t_early_end();
    t_no_start();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule